// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller of a single-channel, 8-bit sampling converter on a parallel bus. It sits between a bus master and an abstracted analog front end. It raises a sample strobe while the input is being acquired, spends a fixed number of clocks on conversion, and then latches the front end's 8-bit value into a result register. The master reads that register over the bus. Completion is flagged either by a one-clock active-low interrupt pulse or by an end-of-conversion level that is low while conversion runs.

Two start modes are offered. In hardware mode a dedicated active-low start pin frames the sampling window: its falling edge opens sampling and its rising edge starts conversion. In software mode a write strobe rising edge starts the first sampling window. After that, each read strobe rising edge that follows a finished conversion starts the next one, and the sampling window lasts a fixed number of clocks. The block drops into a low-power state in two ways. It does so on its own when a finished result is not read in the following clock. It also does so on command when chip select is held inactive. The control settings survive both low-power states.

The result path has no back-pressure. A result stays in its register until the next conversion overwrites it. A reader that misses the clock after completion lets the block fall asleep, but the result remains readable while it sleeps.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A write takes effect on a rising edge of `wr_n` while `cs_n` is low. `addr`=0 selects the mode register, where bit 0 set means software start. `addr`=1 selects the format register, where bit 0 set means level completion signalling and bit 1 set means two's-complement output. Both registers reset to zero, so after reset a write does not start sampling.
- R2: In hardware mode a falling edge on `start_n` raises `sample_o` at the next clock. `sample_o` stays high while `start_n` is held low, and a rising edge of `start_n` ends sampling and begins conversion.
- R3: In software mode, while idle, a `wr_n` rising edge with `cs_n` low starts sampling. Once a conversion has finished and has been read, a `rd_n` rising edge starts the next sampling period.
- R4: In software mode `sample_o` stays high for exactly 6 clocks, and then conversion begins.
- R5: Conversion lasts 8 clocks, with `sample_o` low throughout. At the end of it the front-end value is latched into the result register.
- R6: With bit 0 of the format register clear, `int_n` goes low for exactly one clock right after each conversion, and `eoc` stays high.
- R7: With bit 0 of the format register set, `eoc` is low for all 8 conversion clocks and high otherwise, and `int_n` stays high.
- R8: If `rd_n` is not low with `cs_n` low in the clock after completion, `auto_pd` goes high. A start trigger then clears `auto_pd`, one wake clock follows, and `sample_o` rises the clock after that. A read strobe does not wake the block in hardware mode.
- R9: Holding `cs_n` high for two consecutive clocks raises `soft_pd`. Holding it low for two consecutive clocks clears `soft_pd`. Start edges are ignored in this state, and both control registers keep their values.
- R10: In binary format the result equals the front-end value. In two's-complement format the most significant bit is inverted.
- R11: `dout_en` is high and `dout` carries the result only while both `cs_n` and `rd_n` are low. Otherwise `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; held high it requests power down |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 1 | Register select for writes |
| cfg_din | input | 2 | Write data for the control registers |
| start_n | input | 1 | Hardware start pin, active low |
| ana_data | input | 8 | Value delivered by the analog front end |
| sample_o | output | 1 | High while the input is being sampled |
| eoc | output | 1 | End-of-conversion level, low during conversion in level mode |
| int_n | output | 1 | One-clock active-low completion pulse in pulse mode |
| auto_pd | output | 1 | Automatic power-down state |
| soft_pd | output | 1 | Chip-select power-down state |
| dout | output | 8 | Result bus, zero when not being read |
| dout_en | output | 1 | Result bus drive enable |

## Verification
The hardest state to reach is a wake from automatic power down in which the control settings must still hold. To get there, the stimulus changes the format settings, enters chip-select power down, leaves it, and runs a hardware conversion without reading it. The block then falls asleep on its own. While it sleeps, the bench reads the result, checks that the two's-complement and level settings survived, and confirms that the read did not wake it. A start edge then follows, and the bench checks the single wake clock that comes before sampling resumes.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SAMPLE, ST_CONV, ST_DONE, ST_APD, ST_WAKE, ST_SPD
  } seq_state_e;
endpackage

// File: rtl/adc_pin_track.sv
`timescale 1ns/1ps
// Registered copies of the bus and start pins, used for edge detection.
module adc_pin_track #(
  parameter int               W        = 4,
  parameter logic [W-1:0]     RST_VAL  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] prev
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[i] <= RST_VAL[i];
      else        prev[i] <= pin[i];
    end
  end
endmodule

// File: rtl/adc_ctl_regs.sv
`timescale 1ns/1ps
// Mode and format registers.
module adc_ctl_regs #(
  parameter int CFG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             addr,
  input  logic [CFG_W-1:0] cfg_din,
  output logic             sw_mode,
  output logic             eoc_mode,
  output logic             twos_fmt
);
  logic [CFG_W-1:0] mode_q, fmt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      fmt_q  <= '0;
    end else if (wr_stb) begin
      if (addr) fmt_q  <= cfg_din;
      else      mode_q <= cfg_din;
    end
  end

  assign sw_mode  = mode_q[0];
  assign eoc_mode = fmt_q[0];
  assign twos_fmt = fmt_q[1];

  logic unused_mode;
  assign unused_mode = ^mode_q[CFG_W-1:1];
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
// Sample / convert / power-down sequencer.
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_CLKS = 6,
  parameter int CONV_CLKS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_mode,
  input  logic       wr_stb,
  input  logic       rd_rise,
  input  logic       rd_act,
  input  logic       start_fall,
  input  logic       start_rise,
  input  logic       cs_n,
  input  logic       cs_prev,
  output seq_state_e state,
  output logic       load
);
  localparam int MAXC = (CONV_CLKS > SAMPLE_CLKS) ? CONV_CLKS : SAMPLE_CLKS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SMP_LAST = CW'(SAMPLE_CLKS - 1);
  localparam logic [CW-1:0] CNV_LAST = CW'(CONV_CLKS - 1);

  seq_state_e    nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          trig;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt + 1'b1;
    load    = 1'b0;
    trig    = sw_mode ? (wr_stb | rd_rise) : start_fall;
    case (state)
      ST_IDLE: begin
        cnt_nxt = '0;
        if (trig) nxt = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (!sw_mode) cnt_nxt = '0;
        if (sw_mode ? (cnt == SMP_LAST) : start_rise) begin
          nxt     = ST_CONV;
          cnt_nxt = '0;
        end
      end
      ST_CONV: begin
        if (cnt == CNV_LAST) begin
          nxt  = ST_DONE;
          load = 1'b1;
        end
      end
      ST_DONE: begin
        cnt_nxt = '0;
        if (rd_rise)     nxt = sw_mode ? ST_SAMPLE : ST_IDLE;
        else if (rd_act) nxt = ST_IDLE;
        else             nxt = ST_APD;
      end
      ST_APD: begin
        cnt_nxt = '0;
        if (trig) nxt = ST_WAKE;
      end
      ST_WAKE: begin
        cnt_nxt = '0;
        nxt     = ST_SAMPLE;
      end
      ST_SPD: begin
        cnt_nxt = '0;
        if (!cs_n && !cs_prev) nxt = ST_IDLE;
      end
      default: begin
        cnt_nxt = '0;
        nxt     = ST_IDLE;
      end
    endcase
    if (state != ST_SPD && cs_n && cs_prev) begin
      nxt     = ST_SPD;
      cnt_nxt = '0;
      load    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/adc_result_reg.sv
`timescale 1ns/1ps
// Result latch with format selection and gated bus drive.
module adc_result_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              twos_fmt,
  input  logic [DATA_W-1:0] ana_data,
  input  logic              rd_act,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int MSB = DATA_W - 1;
  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (load) res_q <= twos_fmt ? {~ana_data[MSB], ana_data[MSB-1:0]} : ana_data;
  end

  assign dout    = rd_act ? res_q : '0;
  assign dout_en = rd_act;
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CFG_W       = 2,
  parameter int SAMPLE_CLKS = 6,
  parameter int CONV_CLKS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              addr,
  input  logic [CFG_W-1:0]  cfg_din,
  input  logic              start_n,
  input  logic [DATA_W-1:0] ana_data,
  output logic              sample_o,
  output logic              eoc,
  output logic              int_n,
  output logic              auto_pd,
  output logic              soft_pd,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int NPIN = 4;

  logic [NPIN-1:0] pins, pins_q;
  logic            wr_q, rd_q, st_q, cs_q;
  logic            wr_stb, rd_rise, rd_act, start_fall, start_rise;
  logic            sw_mode, eoc_mode, twos_fmt, load;
  seq_state_e      state;

  assign pins = {cs_n, start_n, rd_n, wr_n};

  adc_pin_track #(.W(NPIN), .RST_VAL(4'b0111)) u_track (
    .clk(clk), .rst_n(rst_n), .pin(pins), .prev(pins_q)
  );
  assign {cs_q, st_q, rd_q, wr_q} = pins_q;

  assign wr_stb     = wr_n & ~wr_q & ~cs_n;
  assign rd_rise    = rd_n & ~rd_q & ~cs_n;
  assign rd_act     = ~rd_n & ~cs_n;
  assign start_fall = ~start_n & st_q;
  assign start_rise = start_n & ~st_q;

  adc_ctl_regs #(.CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .cfg_din(cfg_din),
    .sw_mode(sw_mode), .eoc_mode(eoc_mode), .twos_fmt(twos_fmt)
  );

  adc_seq_fsm #(.SAMPLE_CLKS(SAMPLE_CLKS), .CONV_CLKS(CONV_CLKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .wr_stb(wr_stb),
    .rd_rise(rd_rise), .rd_act(rd_act), .start_fall(start_fall),
    .start_rise(start_rise), .cs_n(cs_n), .cs_prev(cs_q),
    .state(state), .load(load)
  );

  adc_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_n), .load(load), .twos_fmt(twos_fmt),
    .ana_data(ana_data), .rd_act(rd_act), .dout(dout), .dout_en(dout_en)
  );

  assign sample_o = (state == ST_SAMPLE);
  assign eoc      = !(eoc_mode && state == ST_CONV);
  assign int_n    = !(!eoc_mode && state == ST_DONE);
  assign auto_pd  = (state == ST_APD);
  assign soft_pd  = (state == ST_SPD);
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              sample_o,
  input logic              eoc,
  input logic              int_n,
  input logic              auto_pd,
  input logic              soft_pd,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  a_r6_int_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |=> int_n);

  a_r7_eoc_no_int: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> int_n);

  a_r2_conv_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> $past(sample_o));

  a_r11_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

  a_r11_bus_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!cs_n && !rd_n));

  a_r8_single_pd: assert property (@(posedge clk) disable iff (!rst_n)
    !(auto_pd && soft_pd));

  a_r9_spd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_pd) |-> ($past(cs_n) && $past(cs_n, 2)));

  a_r9_spd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    soft_pd |-> (!sample_o && eoc && int_n));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .sample_o(sample_o),
  .eoc(eoc), .int_n(int_n), .auto_pd(auto_pd), .soft_pd(soft_pd),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, addr = 1'b0, start_n = 1'b1;
  logic [1:0] cfg_din = '0;
  logic [7:0] ana_data = '0;
  logic       sample_o, eoc, int_n, auto_pd, soft_pd, dout_en;
  logic [7:0] dout;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .cfg_din(cfg_din), .start_n(start_n), .ana_data(ana_data),
    .sample_o(sample_o), .eoc(eoc), .int_n(int_n), .auto_pd(auto_pd),
    .soft_pd(soft_pd), .dout(dout), .dout_en(dout_en)
  );

  // {front-end value, format register, expected result}
  localparam logic [17:0] VEC [4] = '{
    {8'h3C, 2'd0, 8'h3C},
    {8'h3C, 2'd2, 8'hBC},
    {8'hFF, 2'd1, 8'hFF},
    {8'h00, 2'd3, 8'h80}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_reg(input logic a, input logic [1:0] d);
    addr = a; cfg_din = d; wr_n = 1'b0;
    step();
    wr_n = 1'b1;
    step();
  endtask

  task automatic run_hw(input logic [7:0] ana, input bit lvl);
    ana_data = ana;
    start_n = 1'b0;
    step();
    chk("R2 sampling on start fall", sample_o, 1);
    step();
    chk("R2 sampling held while start low", sample_o, 1);
    start_n = 1'b1;
    step();
    for (int k = 0; k < 8; k++) begin
      chk("R5 no sampling during conversion", sample_o, 0);
      chk("R7 eoc level during conversion", eoc, lvl ? 0 : 1);
      step();
    end
  endtask

  task automatic run_sw(input logic [7:0] ana);
    ana_data = ana;
    for (int k = 0; k < 6; k++) begin
      chk("R4 software sampling window", sample_o, 1);
      step();
    end
    for (int k = 0; k < 8; k++) begin
      chk("R5 conversion clocks", sample_o, 0);
      step();
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R6 int_n idle after reset", int_n, 1);
    chk("R7 eoc idle after reset", eoc, 1);
    chk("R2 no sampling after reset", sample_o, 0);
    chk("R8 awake after reset", auto_pd, 0);
    chk("R11 bus quiet after reset", {dout_en, dout}, 0);

    wr_reg(1'b1, 2'd0);
    chk("R1 reset mode is hardware start", sample_o, 0);

    for (int i = 0; i < 4; i++) begin
      wr_reg(1'b1, VEC[i][9:8]);
      run_hw(VEC[i][17:10], VEC[i][8]);
      chk("R6 R7 completion signal", int_n, VEC[i][8] ? 1 : 0);
      chk("R7 eoc high after conversion", eoc, 1);
      rd_n = 1'b0;
      #1;
      chk("R11 bus enable while reading", dout_en, 1);
      chk("R10 result format", dout, VEC[i][7:0]);
      step();
      chk("R6 int pulse one clock", int_n, 1);
      chk("R8 read prevents power down", auto_pd, 0);
      rd_n = 1'b1;
      step();
      chk("R11 bus quiet after read", {dout_en, dout}, 0);
    end

    // chip-select power down, with format register = level + two's complement
    cs_n = 1'b1;
    step();
    chk("R9 one clock not enough", soft_pd, 0);
    step();
    chk("R9 enter soft power down", soft_pd, 1);
    start_n = 1'b0;
    step();
    chk("R9 start ignored in power down", sample_o, 0);
    start_n = 1'b1;
    step();
    cs_n = 1'b0;
    step();
    chk("R9 one clock not enough to resume", soft_pd, 0 ^ 1);
    step();
    chk("R9 resume from soft power down", soft_pd, 0);

    // hardware conversion left unread
    run_hw(8'h01, 1'b1);
    chk("R7 settings kept, no pulse", int_n, 1);
    step();
    chk("R8 auto power down", auto_pd, 1);
    rd_n = 1'b0;
    #1;
    chk("R9 R10 format kept through power down", dout, 8'h81);
    step();
    rd_n = 1'b1;
    step();
    chk("R8 read does not wake hardware mode", auto_pd, 1);
    start_n = 1'b0;
    step();
    chk("R8 wake clock leaves power down", auto_pd, 0);
    chk("R8 wake clock without sampling", sample_o, 0);
    step();
    chk("R8 sampling after wake", sample_o, 1);
    start_n = 1'b1;
    step();
    for (int k = 0; k < 8; k++) step();
    rd_n = 1'b0;
    step();
    rd_n = 1'b1;
    step();

    // software start
    wr_reg(1'b0, 2'd1);
    chk("R3 mode write does not start", sample_o, 0);
    wr_reg(1'b1, 2'd0);
    chk("R3 write rise starts sampling", sample_o, 1);
    run_sw(8'h5A);
    chk("R6 int pulse after software conversion", int_n, 0);
    chk("R6 eoc stays high in pulse mode", eoc, 1);
    rd_n = 1'b0;
    #1;
    chk("R5 R10 software result", dout, 8'h5A);
    step();
    chk("R3 waiting for read rise", sample_o, 0);
    rd_n = 1'b1;
    step();
    chk("R3 read rise starts next sampling", sample_o, 1);
    run_sw(8'h80);
    chk("R6 second pulse", int_n, 0);
    step();
    chk("R8 unread result powers down", auto_pd, 1);
    chk("R6 no extra pulse", int_n, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule